// File: doc/BRIEF.md
# Partitioned Packed-Element Adder

This block adds two 64-bit words. A two-bit mode input decides how the words are split into packed elements. Each element pair is added on its own, and every element is added in the same operation. The datapath is built from eight byte-wide adder slices. Between neighbouring slices the carry is either passed on or forced to zero, and the mode decides which. One set of slices therefore serves as one 64-bit adder, two 32-bit adders, four 16-bit adders or eight 8-bit adders.

Each element wraps modulo its own width. The carry out of each element is reported in a byte-slot vector. By default the sum and the carry vector are captured in an output register with a synchronous active-high reset. The register can be removed by parameter, which leaves a purely combinational path.

Top module: `psimd_adder`

## Requirements
- R1: With mode 2'b00 the block forms one 64-bit sum modulo 2^64, and the carry out of bit 63 is reported in carry_out[7].
- R2: With mode 2'b01 the block forms two independent 32-bit sums, held in sum[31:0] and sum[63:32]. Their carries are reported in carry_out[3] and carry_out[7].
- R3: With mode 2'b10 the block forms four independent 16-bit sums. The sum for element k is held in sum[16k+15:16k], and its carry is reported in carry_out[2k+1].
- R4: With mode 2'b11 the block forms eight independent 8-bit sums. Byte k of sum holds element k, and its carry is reported in carry_out[k].
- R5: No carry crosses a boundary of the selected element width. An element that overflows wraps to its own low bits and leaves the element above it unchanged.
- R6: A carry_out bit that is not the top byte slot of an element reads as zero.
- R7: With the default output register, sum and carry_out show the result of the operands and mode that were present at the previous rising clock edge.
- R8: A synchronous reset clears sum and carry_out to zero at the next rising edge, even when new operands are present in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Element width: 00=64, 01=32, 10=16, 11=8 bits |
| op_a | input | 64 | First packed operand |
| op_b | input | 64 | Second packed operand |
| sum | output | 64 | Packed element sums |
| carry_out | output | 8 | Per-element carry, in the top byte slot of each element |

## Verification
Two things can land in the same cycle: a carry that the mode must cut at an element boundary, and a carry that the block must report for that element. Operands of all ones plus a one in each element's lowest bit provoke both at once. The bench then checks that every element reads zero and that exactly the top slots of the elements carry. A second collision drives reset together with fresh operands. It is judged by outputs that read zero in the next cycle and by the correct result one cycle after reset is released.

// File: rtl/psimd_pkg.sv
package psimd_pkg;
  typedef enum logic [1:0] {
    EW_64 = 2'b00,
    EW_32 = 2'b01,
    EW_16 = 2'b10,
    EW_08 = 2'b11
  } elem_width_e;
endpackage

// File: rtl/psimd_slice.sv
module psimd_slice #(
  parameter int SLICE_W = 8
) (
  input  logic [SLICE_W-1:0] a,
  input  logic [SLICE_W-1:0] b,
  input  logic               cin,
  output logic [SLICE_W-1:0] s,
  output logic               cout
);
  logic [SLICE_W:0] full;

  always_comb begin
    full = {1'b0, a} + {1'b0, b} + {{SLICE_W{1'b0}}, cin};
    s    = full[SLICE_W-1:0];
    cout = full[SLICE_W];
  end
endmodule

// File: rtl/psimd_link_ctl.sv
module psimd_link_ctl #(
  parameter int N_SLICES = 8
) (
  input  logic [1:0]          mode,
  output logic [N_SLICES-1:0] cut,      // cut[i]: slice i starts an element
  output logic [N_SLICES-1:0] elem_top  // elem_top[i]: slice i ends an element
);
  logic [$clog2(N_SLICES):0] span;

  always_comb begin
    span = ($clog2(N_SLICES)+1)'(N_SLICES >> mode);
    for (int i = 0; i < N_SLICES; i++) begin
      cut[i]      = ((($clog2(N_SLICES)+1)'(i))     & (span - 1'b1)) == '0;
      elem_top[i] = ((($clog2(N_SLICES)+1)'(i + 1)) & (span - 1'b1)) == '0;
    end
  end
endmodule

// File: rtl/psimd_adder.sv
module psimd_adder #(
  parameter int SLICE_W  = 8,
  parameter int N_SLICES = 8,
  parameter bit REG_OUT  = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [1:0]                    mode,
  input  logic [SLICE_W*N_SLICES-1:0]   op_a,
  input  logic [SLICE_W*N_SLICES-1:0]   op_b,
  output logic [SLICE_W*N_SLICES-1:0]   sum,
  output logic [N_SLICES-1:0]           carry_out
);
  import psimd_pkg::*;

  localparam int DW = SLICE_W * N_SLICES;

  logic [N_SLICES-1:0] cut, elem_top;
  logic [N_SLICES-1:0] cin, cout;
  logic [DW-1:0]       sum_c;
  logic [N_SLICES-1:0] carry_c;

  psimd_link_ctl #(.N_SLICES(N_SLICES)) u_link (
    .mode     (mode),
    .cut      (cut),
    .elem_top (elem_top)
  );

  genvar g;
  generate
    for (g = 0; g < N_SLICES; g++) begin : g_slice
      if (g == 0) begin : g_first
        assign cin[g] = 1'b0;
      end else begin : g_rest
        assign cin[g] = cut[g] ? 1'b0 : cout[g-1];
      end
      psimd_slice #(.SLICE_W(SLICE_W)) u_slice (
        .a    (op_a[g*SLICE_W +: SLICE_W]),
        .b    (op_b[g*SLICE_W +: SLICE_W]),
        .cin  (cin[g]),
        .s    (sum_c[g*SLICE_W +: SLICE_W]),
        .cout (cout[g])
      );
    end
  endgenerate

  assign carry_c = cout & elem_top;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          sum       <= '0;
          carry_out <= '0;
        end else begin
          sum       <= sum_c;
          carry_out <= carry_c;
        end
      end

      a_r7_registered_sum: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sum == $past(sum_c)) && (carry_out == $past(carry_c)));
      a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (sum == '0) && (carry_out == '0));
    end else begin : g_comb
      assign sum       = sum_c;
      assign carry_out = carry_c;
    end
  endgenerate

  a_r6_unused_slots_zero: assert property (@(posedge clk) disable iff (rst)
    (carry_c & ~elem_top) == '0);
  a_r5_cut_count: assert property (@(posedge clk) disable iff (rst)
    $countones(cut) == (1 << mode));
  a_r4_byte_mode_all_cut: assert property (@(posedge clk) disable iff (rst)
    (mode == EW_08) |-> (&cut) && (&elem_top));
  a_r1_full_width_single_top: assert property (@(posedge clk) disable iff (rst)
    (mode == EW_64) |-> (elem_top == (N_SLICES'(1) << (N_SLICES-1))));
endmodule

// File: tb/tb_psimd_adder.sv
module tb_psimd_adder;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = '0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [63:0] sum;
  logic [7:0]  carry_out;

  int n_checks = 0;
  int n_fail   = 0;

  // {mode, a, b}
  localparam logic [129:0] VEC [NV] = '{
    {2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001},
    {2'b00, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321},
    {2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001},
    {2'b01, 64'h8000_0000_7FFF_FFFF, 64'h8000_0000_0000_0001},
    {2'b10, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001},
    {2'b10, 64'h00FF_FF00_8000_1234, 64'h0001_0100_8000_4321},
    {2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101},
    {2'b11, 64'h80FF_7F01_C040_00AA, 64'h8001_0101_4040_0055},
    {2'b11, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001},
    {2'b10, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_0001},
    {2'b01, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001},
    {2'b00, 64'hA5A5_A5A5_A5A5_A5A5, 64'h5A5A_5A5A_5A5A_5A5B}
  };

  psimd_adder dut (
    .clk(clk), .rst(rst), .mode(mode), .op_a(op_a), .op_b(op_b),
    .sum(sum), .carry_out(carry_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [71:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic [1:0] m);
    int          ebits = 64 >> m;
    int          nel   = 1 << m;
    logic [64:0] msk   = ({65'b0, 1'b1} << ebits) - 65'd1;
    logic [63:0] r     = '0;
    logic [7:0]  c     = '0;
    for (int e = 0; e < nel; e++) begin
      logic [64:0] fa = ({1'b0, a} >> (e*ebits)) & msk;
      logic [64:0] fb = ({1'b0, b} >> (e*ebits)) & msk;
      logic [64:0] t  = fa + fb;
      r = r | ((t[63:0] & msk[63:0]) << (e*ebits));
      c[(e+1)*(ebits/8)-1] = t[ebits];
    end
    return {c, r};
  endfunction

  function automatic logic [7:0] top_slots(input logic [1:0] m);
    logic [7:0] t = '0;
    for (int i = 0; i < 8; i++) if (((i + 1) % (8 >> m)) == 0) t[i] = 1'b1;
    return t;
  endfunction

  function automatic string mode_req(input logic [1:0] m);
    case (m)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] m, input logic [63:0] a, input logic [63:0] b,
                       input string extra);
    logic [71:0] e = model(a, b, m);
    @(negedge clk);
    mode = m; op_a = a; op_b = b;
    @(negedge clk);              // captured at the posedge in between (R7)
    check64({mode_req(m), "/R7 sum ", extra}, sum, e[63:0]);
    check64({mode_req(m), "/R5 carry ", extra}, {56'b0, carry_out}, {56'b0, e[71:64]});
    check64("R6 unused slots", {56'b0, carry_out & ~top_slots(m)}, 64'b0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check64("R8 reset sum", sum, 64'b0);
    check64("R8 reset carry", {56'b0, carry_out}, 64'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++)
      apply(VEC[i][129:128], VEC[i][127:64], VEC[i][63:0], "table");

    // R5: boundary cut and carry report in the same cycle, byte mode
    apply(2'b11, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, "alt bytes");
    check64("R5 wrap keeps upper byte", sum, 64'h0000_0000_0000_0000);

    // R8: reset together with fresh operands
    @(negedge clk);
    rst = 1'b1; mode = 2'b00; op_a = 64'h1; op_b = 64'h2;
    @(negedge clk);
    check64("R8 reset wins sum", sum, 64'b0);
    check64("R8 reset wins carry", {56'b0, carry_out}, 64'b0);
    rst = 1'b0;
    @(negedge clk);
    check64("R7 after reset release", sum, 64'h3);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule